// File: doc/BRIEF.md
# Channel-Packed Audio Sample FIFO

This block buffers audio samples for one serial audio port. It sits between a register bus and a serializer. A parameter selects the direction. In transmit mode, software writes samples into the data register and the serializer takes them out with a pop strobe. In receive mode, the serializer pushes samples with a strobe and software reads them back from the data register.

The usable depth is set by a 3-bit size code and by the number of active channels. Storage is handed out in channel groups whose size is a power of two, so a 3-channel or a 5-to-7-channel setting leaves part of the storage unused. A control register holds the half-level interrupt mode and a self-clearing flush bit. A status register shows the number of whole frames held, together with sticky overrun and underrun flags.

Top module: `chan_fifo`

## Requirements
- R1: The usable frame depth is min(BASE_WORDS << size_code, MEM_WORDS) shifted right once for each doubling needed to reach the channel count: 0 for 1 channel, 1 for 2, 2 for 3 or 4, and 3 for 5 to 8. The sample capacity is that frame depth times the channel count.
- R2: Samples leave in the order they entered. Only bits 23:0 of a data register write are stored, and bits 31:24 are discarded.
- R3: Status bits 16:8 hold the count of whole frames held, which is floor(samples held / channel count). Register address 2 is status, 1 is control and 0 is data.
- R4: A push while the FIFO holds its full sample capacity is dropped, leaves the stored samples unchanged and sets the sticky overrun flag at status bit 4.
- R5: A pop from an empty FIFO returns zero, moves nothing and sets the sticky underrun flag at status bit 0.
- R6: A write to the status register clears each flag whose bit is written as 0 and keeps each flag whose bit is written as 1. A new error in the same cycle wins over the clear.
- R7: Writing control bit 0 as 1 empties the FIFO at the next clock edge. A serializer strobe in that same cycle is ignored, and the error flags are kept. Control bit 0 always reads back as 0, while control bit 20 reads back as written and bits 31:24 are discarded.
- R8: With control bit 20 set, irq_o is high while the frames held are at or below half the frame depth (transmit), or at or above half the frame depth (receive). With control bit 20 clear, irq_o is low.
- R9: In transmit mode, data writes push and ser_strobe_i pops, with the head sample shown on ser_data_o. A bus read of the data register returns zero and changes nothing. In receive mode, ser_strobe_i pushes ser_data_i, a data read returns the head sample on reg_rdata_o and pops it, and ser_data_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| size_code_i | input | SIZE_W | Storage size code |
| chan_cnt_i | input | 4 | Active channel count, 1 to 8 |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (a data read pops in receive mode) |
| reg_addr_i | input | 2 | Register select: 0 data, 1 control, 2 status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the selected address |
| ser_strobe_i | input | 1 | Serializer pop (transmit) or push (receive) |
| ser_data_i | input | 24 | Sample pushed by the serializer (receive) |
| ser_data_o | output | 24 | Head sample for the serializer (transmit) |
| irq_o | output | 1 | Half-level interrupt request |

## Verification
The storage path is driven with a vector table that interleaves pushes, pops and status reads at two channels. This separates frame counting from sample counting and confirms the output order. Capacity is tested at three channel and size combinations: three channels (a group of four), five channels (a group of eight) and a size code that exceeds the physical storage. Each case is filled one sample past its limit, which shows exactly where overrun begins. Error flags are tested through partial clears and through a clear that coincides with a new error. The flush, the interrupt thresholds and the direction-specific behaviour of the data register are run on both a transmit and a receive instance, since the same stimulus must give opposite results on the two.

// File: rtl/chan_fifo_pkg.sv
package chan_fifo_pkg;
  typedef enum logic {FIFO_TX = 1'b0, FIFO_RX = 1'b1} fifo_dir_e;

  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] A_DATA = 2'd0;
  localparam logic [REG_AW-1:0] A_CTRL = 2'd1;
  localparam logic [REG_AW-1:0] A_STAT = 2'd2;

  localparam int BUS_W      = 32;
  localparam int KEEP_W     = 24;
  localparam int CTRL_CLR   = 0;
  localparam int CTRL_HALF  = 20;
  localparam int ST_UNDER   = 0;
  localparam int ST_OVER    = 4;
  localparam int ST_CNT_LSB = 8;
  localparam int ST_CNT_W   = 9;
  localparam int CHAN_W     = 4;
  localparam int SHIFT_W    = 2;

  function automatic logic [CHAN_W-1:0] chan_clip(input logic [CHAN_W-1:0] c);
    if (c == '0) return CHAN_W'(1);
    if (c > CHAN_W'(8)) return CHAN_W'(8);
    return c;
  endfunction

  // doublings to reach the channel count
  function automatic logic [SHIFT_W-1:0] group_shift(input logic [CHAN_W-1:0] c);
    if (c <= CHAN_W'(1)) return SHIFT_W'(0);
    if (c == CHAN_W'(2)) return SHIFT_W'(1);
    if (c <= CHAN_W'(4)) return SHIFT_W'(2);
    return SHIFT_W'(3);
  endfunction
endpackage

// File: rtl/chan_fifo_geom.sv
module chan_fifo_geom
  import chan_fifo_pkg::*;
#(
  parameter int BASE_WORDS = 256,
  parameter int MEM_WORDS  = 256,
  parameter int SIZE_W     = 3,
  parameter int CNT_W      = $clog2(MEM_WORDS) + 1
) (
  input  logic [SIZE_W-1:0] size_code_i,
  input  logic [CHAN_W-1:0] chan_i,
  output logic [CHAN_W-1:0] chan_o,
  output logic [CNT_W-1:0]  depth_frames_o,
  output logic [CNT_W-1:0]  cap_words_o
);
  localparam int WIDE_W = CNT_W + (2 ** SIZE_W);

  logic [WIDE_W-1:0]  base_w, clamp_w, depth_w, cap_w;
  logic [SHIFT_W-1:0] sh;

  always_comb begin
    chan_o  = chan_clip(chan_i);
    sh      = group_shift(chan_o);
    base_w  = WIDE_W'(BASE_WORDS) << size_code_i;
    clamp_w = (base_w > WIDE_W'(MEM_WORDS)) ? WIDE_W'(MEM_WORDS) : base_w;
    depth_w = clamp_w >> sh;
    cap_w   = depth_w * WIDE_W'(chan_o);
  end

  assign depth_frames_o = CNT_W'(depth_w);
  assign cap_words_o    = CNT_W'(cap_w);
endmodule

// File: rtl/chan_fifo_store.sv
module chan_fifo_store #(
  parameter int DATA_W    = 24,
  parameter int MEM_WORDS = 256,
  parameter int CNT_W     = $clog2(MEM_WORDS) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic [CNT_W-1:0]  cap_words_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [DATA_W-1:0] head_o,
  output logic              push_drop_o,
  output logic              pop_miss_o
);
  localparam int PTR_W = $clog2(MEM_WORDS);

  logic [DATA_W-1:0] mem [MEM_WORDS];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic              full, empty, push_ok, pop_ok;

  assign full    = count >= cap_words_i;
  assign empty   = count == '0;
  assign push_ok = push_i & ~clr_i & ~full;
  assign pop_ok  = pop_i & ~clr_i & ~empty;

  assign push_drop_o = push_i & ~clr_i & full;
  assign pop_miss_o  = pop_i & ~clr_i & empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop_ok)  rd_ptr <= rd_ptr + PTR_W'(1);
      count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr] <= push_data_i;
  end

  assign head_o  = empty ? '0 : mem[rd_ptr];
  assign count_o = count;

  a_r4_drop_holds_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i && !clr_i) |=> (count == $past(count)));
  a_r5_miss_no_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty && !push_i && !clr_i) |=> (count == '0 && rd_ptr == $past(rd_ptr)));
  a_r7_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count == '0 && head_o == '0));
endmodule

// File: rtl/chan_fifo_flags.sv
module chan_fifo_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_over_i,
  input  logic set_under_i,
  input  logic wr_i,
  input  logic keep_over_i,
  input  logic keep_under_i,
  output logic over_o,
  output logic under_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      over_o  <= 1'b0;
      under_o <= 1'b0;
    end else begin
      over_o  <= set_over_i  | (over_o  & ~(wr_i & ~keep_over_i));
      under_o <= set_under_i | (under_o & ~(wr_i & ~keep_under_i));
    end
  end

  a_r4_over_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_over_i |=> over_o);
  a_r5_under_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_under_i |=> under_o);
  a_r6_zero_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !keep_over_i && !set_over_i) |=> !over_o);
  a_r6_one_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && keep_under_i && under_o) |=> under_o);
endmodule

// File: rtl/chan_fifo.sv
module chan_fifo
  import chan_fifo_pkg::*;
#(
  parameter fifo_dir_e DIR        = FIFO_TX,
  parameter int        BASE_WORDS = 256,
  parameter int        MEM_WORDS  = 256,
  parameter int        SIZE_W     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SIZE_W-1:0] size_code_i,
  input  logic [3:0]        chan_cnt_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              ser_strobe_i,
  input  logic [23:0]       ser_data_i,
  output logic [23:0]       ser_data_o,
  output logic              irq_o
);
  localparam int CNT_W = $clog2(MEM_WORDS) + 1;

  logic [CHAN_W-1:0] chan;
  logic [CNT_W-1:0]  depth_frames, cap_words, count, frames, half_lvl;
  logic [KEEP_W-1:0] push_data, head, data_rd_val;
  logic              push, pop, push_drop, pop_miss;
  logic              half_mode, clr, stat_wr, over, under;
  logic              unused_in;

  assign unused_in = ^{reg_wdata_i, ser_data_i, reg_re_i};

  chan_fifo_geom #(
    .BASE_WORDS(BASE_WORDS), .MEM_WORDS(MEM_WORDS), .SIZE_W(SIZE_W), .CNT_W(CNT_W)
  ) i_geom (
    .size_code_i   (size_code_i),
    .chan_i        (chan_cnt_i),
    .chan_o        (chan),
    .depth_frames_o(depth_frames),
    .cap_words_o   (cap_words)
  );

  assign clr     = reg_we_i & (reg_addr_i == A_CTRL) & reg_wdata_i[CTRL_CLR];
  assign stat_wr = reg_we_i & (reg_addr_i == A_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) half_mode <= 1'b0;
    else if (reg_we_i && reg_addr_i == A_CTRL) half_mode <= reg_wdata_i[CTRL_HALF];
  end

  chan_fifo_store #(
    .DATA_W(KEEP_W), .MEM_WORDS(MEM_WORDS), .CNT_W(CNT_W)
  ) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .push_i     (push),
    .push_data_i(push_data),
    .pop_i      (pop),
    .cap_words_i(cap_words),
    .count_o    (count),
    .head_o     (head),
    .push_drop_o(push_drop),
    .pop_miss_o (pop_miss)
  );

  chan_fifo_flags i_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_over_i  (push_drop),
    .set_under_i (pop_miss),
    .wr_i        (stat_wr),
    .keep_over_i (reg_wdata_i[ST_OVER]),
    .keep_under_i(reg_wdata_i[ST_UNDER]),
    .over_o      (over),
    .under_o     (under)
  );

  // whole frames held: samples / channels
  always_comb begin
    case (chan)
      4'd1:    frames = count;
      4'd2:    frames = count >> 1;
      4'd3:    frames = count / CNT_W'(3);
      4'd4:    frames = count >> 2;
      4'd5:    frames = count / CNT_W'(5);
      4'd6:    frames = count / CNT_W'(6);
      4'd7:    frames = count / CNT_W'(7);
      default: frames = count >> 3;
    endcase
  end

  assign half_lvl = depth_frames >> 1;

  generate
    if (DIR == FIFO_TX) begin : g_tx
      assign push        = reg_we_i & (reg_addr_i == A_DATA);
      assign push_data   = reg_wdata_i[KEEP_W-1:0];
      assign pop         = ser_strobe_i;
      assign ser_data_o  = head;
      assign data_rd_val = '0;
      assign irq_o       = half_mode & (frames <= half_lvl);
    end else begin : g_rx
      assign push        = ser_strobe_i;
      assign push_data   = ser_data_i;
      assign pop         = reg_re_i & (reg_addr_i == A_DATA);
      assign ser_data_o  = '0;
      assign data_rd_val = head;
      assign irq_o       = half_mode & (frames >= half_lvl);
    end
  endgenerate

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_DATA: reg_rdata_o[KEEP_W-1:0] = data_rd_val;
      A_CTRL: reg_rdata_o[CTRL_HALF] = half_mode;
      A_STAT: begin
        reg_rdata_o[ST_CNT_LSB +: ST_CNT_W] = ST_CNT_W'(frames);
        reg_rdata_o[ST_OVER]  = over;
        reg_rdata_o[ST_UNDER] = under;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  a_r8_irq_needs_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !half_mode |-> !irq_o);
  a_r7_clr_bit_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_CTRL) |-> !reg_rdata_o[CTRL_CLR]);
endmodule

// File: tb/test_chan_fifo.sv
`timescale 1ns/1ps
module test_chan_fifo;
  import chan_fifo_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] size_code = '0;
  logic [3:0] chan = 4'd2;

  logic t_we = 0, t_re = 0, t_st = 0;
  logic [1:0] t_a = '0;
  logic [31:0] t_wd = '0, t_rd;
  logic [23:0] t_sd = '0, t_so;
  logic t_irq;
  logic r_we = 0, r_re = 0, r_st = 0;
  logic [1:0] r_a = '0;
  logic [31:0] r_wd = '0, r_rd;
  logic [23:0] r_sd = '0, r_so;
  logic r_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  chan_fifo #(.DIR(FIFO_TX), .BASE_WORDS(8), .MEM_WORDS(32)) i_chan_fifo (
    .clk_i(clk), .rst_ni(rst_n), .size_code_i(size_code), .chan_cnt_i(chan),
    .reg_we_i(t_we), .reg_re_i(t_re), .reg_addr_i(t_a), .reg_wdata_i(t_wd),
    .reg_rdata_o(t_rd), .ser_strobe_i(t_st), .ser_data_i(t_sd), .ser_data_o(t_so),
    .irq_o(t_irq));

  chan_fifo #(.DIR(FIFO_RX), .BASE_WORDS(8), .MEM_WORDS(32)) i_chan_fifo_rx (
    .clk_i(clk), .rst_ni(rst_n), .size_code_i(size_code), .chan_cnt_i(chan),
    .reg_we_i(r_we), .reg_re_i(r_re), .reg_addr_i(r_a), .reg_wdata_i(r_wd),
    .reg_rdata_o(r_rd), .ser_strobe_i(r_st), .ser_data_i(r_sd), .ser_data_o(r_so),
    .irq_o(r_irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit rx, input logic we, input logic re, input logic [1:0] a,
                     input logic [31:0] wd, input logic st, input logic [23:0] sd,
                     output logic [31:0] rd, output logic [23:0] so);
    @(negedge clk);
    if (rx) begin r_we = we; r_re = re; r_a = a; r_wd = wd; r_st = st; r_sd = sd; end
    else    begin t_we = we; t_re = re; t_a = a; t_wd = wd; t_st = st; t_sd = sd; end
    #1;
    rd = rx ? r_rd : t_rd;
    so = rx ? r_so : t_so;
    @(posedge clk); #1;
    t_we = 0; t_re = 0; t_st = 0; r_we = 0; r_re = 0; r_st = 0;
  endtask

  task automatic wr(input bit rx, input logic [1:0] a, input logic [31:0] d);
    logic [31:0] rd; logic [23:0] so;
    cyc(rx, 1'b1, 1'b0, a, d, 1'b0, '0, rd, so);
  endtask

  task automatic rdr(input bit rx, input logic [1:0] a, output logic [31:0] v);
    logic [23:0] so;
    cyc(rx, 1'b0, 1'b1, a, '0, 1'b0, '0, v, so);
  endtask

  task automatic ser(input bit rx, input logic [23:0] d, output logic [23:0] so);
    logic [31:0] rd;
    cyc(rx, 1'b0, 1'b0, A_DATA, '0, 1'b1, d, rd, so);
  endtask

  task automatic flush(input bit rx);
    wr(rx, A_CTRL, 32'h1);
    wr(rx, A_STAT, 32'h0);
  endtask

  // op: 0 push via bus, 1 serializer pop (check data), 2 status read (check word)
  localparam logic [57:0] VEC [15] = '{
    {2'd0, 24'h111111, 32'h0},   {2'd2, 24'h0, 32'h000},
    {2'd0, 24'h222222, 32'h0},   {2'd2, 24'h0, 32'h100},
    {2'd0, 24'h333333, 32'h0},   {2'd0, 24'h444444, 32'h0},
    {2'd0, 24'h555555, 32'h0},   {2'd2, 24'h0, 32'h200},
    {2'd1, 24'h0, 32'h111111},   {2'd1, 24'h0, 32'h222222},
    {2'd2, 24'h0, 32'h100},      {2'd1, 24'h0, 32'h333333},
    {2'd1, 24'h0, 32'h444444},   {2'd1, 24'h0, 32'h555555},
    {2'd2, 24'h0, 32'h000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v; logic [23:0] so;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // reset state
    rdr(0, A_STAT, v); chk("R3 reset tx status", v, 32'h0);
    rdr(1, A_STAT, v); chk("R3 reset rx status", v, 32'h0);
    chk("R8 reset irq", {30'b0, t_irq, r_irq}, 32'h0);
    chk("R9 reset ser_data_o", {8'b0, t_so}, 32'h0);

    // table: 2 channels, size 0 -> 4 frames, 8 samples
    wr(0, A_CTRL, 32'h100000);
    for (int i = 0; i < 15; i++) begin
      case (VEC[i][57:56])
        2'd0: wr(0, A_DATA, {8'h0, VEC[i][55:32]});
        2'd1: begin ser(0, '0, so); chk("R2 table pop order", {8'h0, so}, VEC[i][31:0]); end
        default: begin rdr(0, A_STAT, v); chk("R3 table frame count", v, VEC[i][31:0]); end
      endcase
    end

    // R2 upper bits discarded
    flush(0);
    wr(0, A_DATA, 32'hFF123456);
    ser(0, '0, so); chk("R2 data bits 31:24 dropped", {8'h0, so}, 32'h123456);
    wr(0, A_CTRL, 32'hFF100000);
    rdr(0, A_CTRL, v); chk("R7 ctrl readback", v, 32'h100000);

    // R1/R3/R4: 3 channels -> group of 4: 2 frames, 6 samples
    chan = 4'd3; size_code = 3'd0; flush(0);
    for (int i = 0; i < 5; i++) wr(0, A_DATA, 32'(i + 1));
    rdr(0, A_STAT, v); chk("R3 floor frames 5/3", v, 32'h100);
    for (int i = 5; i < 7; i++) wr(0, A_DATA, 32'(i + 1));
    rdr(0, A_STAT, v); chk("R1 R4 cap 6 at 3ch", v, 32'h210);
    ser(0, '0, so); chk("R4 drop keeps head", {8'h0, so}, 32'h1);

    // 5 channels, size 2 -> 4 frames, 20 samples
    chan = 4'd5; size_code = 3'd2; flush(0);
    for (int i = 0; i < 20; i++) wr(0, A_DATA, 32'(i));
    rdr(0, A_STAT, v); chk("R1 full at 5ch no overrun", v, 32'h400);
    wr(0, A_DATA, 32'h99);
    rdr(0, A_STAT, v); chk("R4 overrun at 5ch", v, 32'h410);

    // 1 channel, size 3 clamps to storage 32
    chan = 4'd1; size_code = 3'd3; flush(0);
    for (int i = 0; i < 32; i++) wr(0, A_DATA, 32'(i));
    rdr(0, A_STAT, v); chk("R1 clamp to storage", v, 32'h2000);
    wr(0, A_DATA, 32'h99);
    rdr(0, A_STAT, v); chk("R4 overrun after clamp", v, 32'h2010);

    // R5 underrun on tx
    size_code = 3'd0; flush(0);
    ser(0, '0, so); chk("R5 empty pop zero", {8'h0, so}, 32'h0);
    rdr(0, A_STAT, v); chk("R5 underrun flag", v, 32'h001);

    // R6 partial clears
    for (int i = 0; i < 9; i++) wr(0, A_DATA, 32'(i));
    rdr(0, A_STAT, v); chk("R6 setup both flags", v, 32'h811);
    wr(0, A_STAT, 32'h10);
    rdr(0, A_STAT, v); chk("R6 keep over clear under", v, 32'h810);
    wr(0, A_STAT, 32'h0);
    rdr(0, A_STAT, v); chk("R6 clear all", v, 32'h800);
    flush(0);
    cyc(0, 1'b1, 1'b0, A_STAT, 32'h0, 1'b1, '0, v, so);
    rdr(0, A_STAT, v); chk("R6 new error wins", v, 32'h001);

    // R7 clear keeps flags
    wr(0, A_DATA, 32'h5); wr(0, A_DATA, 32'h6);
    wr(0, A_CTRL, 32'h1);
    rdr(0, A_STAT, v); chk("R7 clear keeps flags", v, 32'h001);

    // R7 clear ignores same-cycle strobe (rx)
    flush(1);
    ser(1, 24'h1, so); ser(1, 24'h2, so);
    cyc(1, 1'b1, 1'b0, A_CTRL, 32'h100001, 1'b1, 24'h777777, v, so);
    rdr(1, A_STAT, v); chk("R7 clear with strobe", v, 32'h0);
    rdr(1, A_CTRL, v); chk("R7 clear bit self-clears", v, 32'h100000);

    // R8 tx: 1ch size0 -> depth 8, half 4
    flush(0); wr(0, A_CTRL, 32'h100000);
    chk("R8 tx empty irq", {31'b0, t_irq}, 32'h1);
    for (int i = 0; i < 4; i++) wr(0, A_DATA, 32'(i));
    chk("R8 tx at half irq", {31'b0, t_irq}, 32'h1);
    wr(0, A_DATA, 32'h4);
    chk("R8 tx above half", {31'b0, t_irq}, 32'h0);
    ser(0, '0, so); wr(0, A_CTRL, 32'h0);
    chk("R8 tx mode off", {31'b0, t_irq}, 32'h0);

    // R8 rx
    flush(1); wr(1, A_CTRL, 32'h100000);
    for (int i = 0; i < 3; i++) ser(1, 24'(i), so);
    chk("R8 rx below half", {31'b0, r_irq}, 32'h0);
    ser(1, 24'h3, so);
    chk("R8 rx at half", {31'b0, r_irq}, 32'h1);

    // R9 rx read path
    flush(1);
    ser(1, 24'hABCDEF, so); ser(1, 24'h123456, so);
    chk("R9 rx ser_data_o zero", {8'h0, so}, 32'h0);
    rdr(1, A_DATA, v); chk("R9 rx read first", v, 32'hABCDEF);
    rdr(1, A_DATA, v); chk("R9 rx read second", v, 32'h123456);
    rdr(1, A_DATA, v); chk("R5 rx empty read zero", v, 32'h0);
    rdr(1, A_STAT, v); chk("R5 rx underrun", v, 32'h001);

    // R9 tx data read has no effect
    flush(0);
    wr(0, A_DATA, 32'h42);
    rdr(0, A_DATA, v); chk("R9 tx data read zero", v, 32'h0);
    rdr(0, A_STAT, v); chk("R9 tx read no pop", v, 32'h100);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule